// File: doc/BRIEF.md
# Multi-Channel Gated Clock Composite Controller

This block produces up to sixteen clock-enable strobes from a small set of reference strobes. Every source and every output is a one-cycle enable pulse in a single clock domain. Each output channel passes its chosen source through three stages in a fixed order: a four-way selector, then a divider by a power of two, then a gate.

Three 32-bit control words set up the channels. A simple write and read port reaches them. One word holds a disable bit per channel. The other two words each hold a 2-bit field per channel: one field picks the source, the other gives the divider exponent.

Software opens a channel by clearing its disable bit. Reprogramming one channel leaves every other channel running undisturbed.

Top module: `clkc_top`

## Requirements
- R1: After reset, the word at offset 0x0 reads with bits [NUM_CH-1:0] all 1 and the upper bits 0. The words at offsets 0x4 and 0x8 read 0, and every channel output is low.
- R2: A write to offset 0x0, 0x4 or 0x8 takes effect at that clock edge. A read of the same offset in the next cycle returns the written value, with bits above NUM_CH-1 of offset 0x0 reading 0.
- R3: While bit i of the word at offset 0x0 is 1, channel i's output stays low.
- R4: Bits [2i+1:2i] of the word at offset 0x4 pick the source for channel i. A value s selects source strobe s.
- R5: Bits [2i+1:2i] of the word at offset 0x8 hold an exponent k. Channel i then emits one output strobe for every 2^k strobes of its selected source (1, 2, 4 or 8), and two output strobes are never adjacent when k > 0.
- R6: An output strobe is high in the cycle after the clock edge that sampled the source strobe completing the count. No output strobe occurs unless some source strobe was high at the previous edge.
- R7: Closing a channel clears its divide counter. After the channel is reopened, its first output strobe follows the 2^k-th selected source strobe counted from the reopening.
- R8: A write that changes only other channels' fields leaves a channel's output sequence unchanged.
- R9: Offsets other than 0x0, 0x4 and 0x8 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Write strobe for the control words |
| reg_addr | input | 4 | Byte offset of the control word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| src_en | input | NUM_SRC | Source clock-enable strobes |
| ch_en | output | NUM_CH | Per-channel output clock-enable strobes |

## Verification
The sources are driven with four distinct rhythms: always high, every second cycle, every third cycle, and a pseudo-random bit. Pulse counts over fixed windows therefore show both which source a channel took and which divide ratio it applied. The channels start with a staggered mix of selector and exponent values, so a swapped field or a shifted bit position changes the output of a specific channel. A cycle-exact reference model checks every output cycle while gates close and reopen and while neighbouring fields are rewritten in mid-run. This exposes counter-restart, latency and crosstalk faults.

// File: rtl/clkc_pkg.sv
package clkc_pkg;
    localparam int REG_ADDR_W = 4;
    localparam int FLD_W      = 2;
    localparam logic [REG_ADDR_W-1:0] OFS_GATE = 4'h0;
    localparam logic [REG_ADDR_W-1:0] OFS_MUX  = 4'h4;
    localparam logic [REG_ADDR_W-1:0] OFS_DIV  = 4'h8;
    typedef logic [FLD_W-1:0] fld_t;
endpackage

// File: rtl/clkc_regs.sv
module clkc_regs
    import clkc_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [REG_ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic [NUM_CH-1:0]       gate_o,
    output logic [FLD_W*NUM_CH-1:0] mux_o,
    output logic [FLD_W*NUM_CH-1:0] div_o
);
    localparam int PACK_W = FLD_W * NUM_CH;

    typedef struct packed {
        logic [NUM_CH-1:0] gate;
        logic [PACK_W-1:0] mux;
        logic [PACK_W-1:0] div;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        if (we) begin
            case (addr)
                OFS_GATE: st_d.gate = wdata[NUM_CH-1:0];
                OFS_MUX:  st_d.mux  = wdata[PACK_W-1:0];
                OFS_DIV:  st_d.div  = wdata[PACK_W-1:0];
                default:  ;
            endcase
        end
        case (addr)
            OFS_GATE: rdata = DATA_W'(st_q.gate);
            OFS_MUX:  rdata = DATA_W'(st_q.mux);
            OFS_DIV:  rdata = DATA_W'(st_q.div);
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.gate <= '1;
            st_q.mux  <= '0;
            st_q.div  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate;
    assign mux_o  = st_q.mux;
    assign div_o  = st_q.div;
endmodule

// File: rtl/clkc_chan.sv
module clkc_chan
    import clkc_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_en,
    input  fld_t               sel,
    input  fld_t               div_exp,
    input  logic               gate_off,
    output logic               strobe
);
    localparam int CNT_W = (1 << FLD_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
    } ch_t;

    ch_t ch_d, ch_q;
    logic             hit;
    logic [CNT_W-1:0] limit;

    always_comb begin
        hit   = (int'(sel) < NUM_SRC) ? src_en[sel] : 1'b0;
        limit = ~({CNT_W{1'b1}} << div_exp);
        ch_d     = ch_q;
        ch_d.out = 1'b0;
        if (gate_off) begin
            ch_d.cnt = '0;
        end else if (hit) begin
            if (ch_q.cnt >= limit) begin
                ch_d.cnt = '0;
                ch_d.out = 1'b1;
            end else begin
                ch_d.cnt = ch_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ch_q <= '0;
        else     ch_q <= ch_d;
    end

    assign strobe = ch_q.out;
endmodule

// File: rtl/clkc_top.sv
module clkc_top
    import clkc_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_SRC-1:0]    src_en,
    output logic [NUM_CH-1:0]     ch_en
);
    localparam int PACK_W = FLD_W * NUM_CH;

    logic [NUM_CH-1:0] gate_w;
    logic [PACK_W-1:0] mux_w;
    logic [PACK_W-1:0] div_w;

    clkc_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .gate_o (gate_w),
        .mux_o  (mux_w),
        .div_o  (div_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        clkc_chan #(.NUM_SRC(NUM_SRC)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .src_en   (src_en),
            .sel      (mux_w[FLD_W*g +: FLD_W]),
            .div_exp  (div_w[FLD_W*g +: FLD_W]),
            .gate_off (gate_w[g]),
            .strobe   (ch_en[g])
        );
    end
endmodule

// File: rtl/clkc_top_chk.sv
module clkc_top_chk
    import clkc_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      reg_we,
    input logic [REG_ADDR_W-1:0]     reg_addr,
    input logic [DATA_W-1:0]         reg_rdata,
    input logic [NUM_SRC-1:0]        src_en,
    input logic [NUM_CH-1:0]         ch_en,
    input logic [NUM_CH-1:0]         gate_q,
    input logic [FLD_W*NUM_CH-1:0]   div_q
);
    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr != OFS_GATE && reg_addr != OFS_MUX && reg_addr != OFS_DIV) |-> reg_rdata == '0);

    a_r2_gate_holds_without_write: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == OFS_GATE) |=> $stable(gate_q));

    a_r6_output_needs_source: assert property (@(posedge clk) disable iff (rst)
        (ch_en != '0) |-> $past(src_en != '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        a_r3_closed_output_low: assert property (@(posedge clk) disable iff (rst)
            gate_q[i] |=> !ch_en[i]);

        a_r5_no_adjacent_pulses: assert property (@(posedge clk) disable iff (rst)
            (ch_en[i] && div_q[FLD_W*i +: FLD_W] != '0) |=> !ch_en[i]);
    end
endmodule

bind clkc_top clkc_top_chk #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .src_en    (src_en),
    .ch_en     (ch_en),
    .gate_q    (gate_w),
    .div_q     (div_w)
);

// File: tb/sim_clkc_top.sv
module sim_clkc_top;
    localparam int NCH = 16;
    localparam int NSRC = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = 4'h0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NSRC-1:0] src_en = '0;
    logic [NCH-1:0]  ch_en;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    clkc_top #(.NUM_CH(NCH), .NUM_SRC(NSRC), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_en(src_en), .ch_en(ch_en)
    );

    // source rhythms: always, every 2nd, every 3rd, pseudo-random
    int       cyc = 0;
    logic [7:0] lfsr = 8'h5A;
    always @(negedge clk) begin
        cyc  <= cyc + 1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        src_en <= {lfsr[0], (cyc % 3 == 0), cyc[0], 1'b1};
    end

    // reference model (register state and divide counters)
    logic [NCH-1:0]   m_gate;
    logic [2*NCH-1:0] m_mux;
    logic [2*NCH-1:0] m_div;
    int               m_cnt [NCH];
    logic [NCH-1:0]   exp_q [$];

    always @(posedge clk) begin
        logic [NCH-1:0] e;
        e = '0;
        if (rst) begin
            m_gate = '1; m_mux = '0; m_div = '0;
            for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                int lim;
                logic hit;
                hit = src_en[m_mux[2*i +: 2]];
                lim = (1 << m_div[2*i +: 2]) - 1;
                if (m_gate[i]) m_cnt[i] = 0;
                else if (hit) begin
                    if (m_cnt[i] >= lim) begin e[i] = 1'b1; m_cnt[i] = 0; end
                    else m_cnt[i] = m_cnt[i] + 1;
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    4'h0: m_gate = reg_wdata[NCH-1:0];
                    4'h4: m_mux  = reg_wdata[2*NCH-1:0];
                    4'h8: m_div  = reg_wdata[2*NCH-1:0];
                    default: ;
                endcase
            end
        end
        exp_q.push_back(e);
    end

    // monitor: compare every output cycle against the model
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [NCH-1:0] e;
            e = exp_q.pop_front();
            n_run++;
            if (ch_en !== e) begin
                n_fail++;
                $display("FAIL %s scoreboard ch_en got %h exp %h", cur_req, ch_en, e);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, req, $sformatf("read @%h", a), reg_rdata, exp);
    endtask

    task automatic count_pulses(input int idx, input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (ch_en[idx]) c++;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        cur_req = "R1";
        rd(4'h0, 32'h0000_FFFF, "R1");
        rd(4'h4, 32'h0, "R1");
        rd(4'h8, 32'h0, "R1");
        chk(ch_en === '0, "R1", "outputs after reset", 32'(ch_en), 32'h0);

        // R9: unmapped offsets
        cur_req = "R9";
        rd(4'hC, 32'h0, "R9");
        wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h2, 32'h1234_5678);
        rd(4'h0, 32'h0000_FFFF, "R9");
        rd(4'h4, 32'h0, "R9");
        rd(4'h8, 32'h0, "R9");

        // R2: program and read back
        cur_req = "R2";
        wr(4'h4, 32'hE4E4_E4E4);
        wr(4'h8, 32'hFFAA_5500);
        wr(4'h0, 32'hFFFF_0000);
        rd(4'h0, 32'h0, "R2");
        rd(4'h4, 32'hE4E4_E4E4, "R2");
        rd(4'h8, 32'hFFAA_5500, "R2");

        // R4: source choice seen through pulse counts
        cur_req = "R4";
        repeat (20) @(negedge clk);
        count_pulses(0, 60, c);  chk(c == 60, "R4", "ch0 src0 count", c, 60);
        count_pulses(1, 60, c);  chk(c == 30, "R4", "ch1 src1 count", c, 30);
        count_pulses(2, 60, c);  chk(c == 20, "R4", "ch2 src2 count", c, 20);
        repeat (80) @(negedge clk);

        // R5: divide ratios on the always-on source
        cur_req = "R5";
        count_pulses(4, 64, c);  chk(c == 32, "R5", "ch4 div2 count", c, 32);
        count_pulses(8, 64, c);  chk(c == 16, "R5", "ch8 div4 count", c, 16);
        count_pulses(12, 64, c); chk(c == 8,  "R5", "ch12 div8 count", c, 8);

        // R6: one-cycle latency from source strobe
        cur_req = "R6";
        begin
            bit s;
            do begin @(posedge clk); s = src_en[1]; end while (!s);
            @(negedge clk);
            chk(ch_en[1] === 1'b1, "R6", "ch1 after src1 high", 32'(ch_en[1]), 32'h1);
            do begin @(posedge clk); s = src_en[1]; end while (s);
            @(negedge clk);
            chk(ch_en[1] === 1'b0, "R6", "ch1 after src1 low", 32'(ch_en[1]), 32'h0);
        end

        // R3: closed gate holds output low
        cur_req = "R3";
        wr(4'h0, 32'h0000_0020);
        count_pulses(5, 40, c);  chk(c == 0, "R3", "ch5 closed count", c, 0);
        count_pulses(0, 40, c);  chk(c == 40, "R3", "ch0 open count", c, 40);

        // R7: counter restarts on reopen
        cur_req = "R7";
        wr(4'h0, 32'h0000_1000);
        repeat (5) @(negedge clk);
        wr(4'h0, 32'h0000_0000);
        c = 0;
        do begin @(negedge clk); c++; end while (!ch_en[12] && c < 50);
        chk(c == 8, "R7", "ch12 first pulse delay", c, 8);

        // R8: rewriting neighbours leaves ch0 and ch12 untouched
        cur_req = "R8";
        fork
            count_pulses(0, 64, c);
            begin
                wr(4'h4, 32'hE4E4_E424);
                wr(4'h8, 32'hFFAA_5700);
                wr(4'h0, 32'h0000_0F0E);
                wr(4'h4, 32'hE4E4_E4F4);
                wr(4'h0, 32'h0000_0000);
            end
        join
        chk(c == 64, "R8", "ch0 count during neighbour writes", c, 64);
        repeat (100) @(negedge clk);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule